// File: doc/BRIEF.md
# Fractional Audio Clock Divider

This block turns a fast source clock into two clock-enable streams for an audio serial port. The master-clock stream pulses once per master period. Its average period is N + b/a source cycles, where N is an integer divisor and b/a is a fraction. A running remainder accumulator decides which periods are one source cycle longer, so the b extra cycles are spread across each run of a master periods instead of being bunched together.

The bit-clock stream is then derived from the master-clock pulses through a second integer divisor M, which is typically 8. The block gives a bit-clock pulse on every M-th master pulse, together with a bit-clock level that spends about half of each bit period low and half high.

All divisor inputs are held static while `en` is high. Dropping `en` clears every counter and the accumulator, and holds the outputs low.

The master sequencer is a three-state machine:
- S_IDLE moves to S_COUNT when `en` is sampled high.
- S_COUNT stays in S_COUNT while counting. At the end of a plain period it restarts its count and stays in S_COUNT. At the end of a period that must be stretched, it moves to S_EXTRA.
- S_EXTRA always returns to S_COUNT.
- Every state moves to S_IDLE when `en` is sampled low.

Top module: `frac_aclk_div`

## Requirements
- R1: While asynchronous reset is active, and from the cycle after `en` is sampled low, `mclk_en`, `bclk_en` and `bclk_lvl` are all 0.
- R2: After `en` is first sampled high at a clock edge, the first `mclk_en` pulse is high in the Nc-th cycle after that edge. Here Nc = max(`int_div`, 2).
- R3: Every master period is measured as the number of cycles from one `mclk_en` pulse to the next. Each one is either Nc or Nc+1 cycles.
- R4: The fraction is valid when 1 <= b < a. In that case, the first a master periods after enable total exactly a*Nc + b cycles. The same holds for each later group of a periods.
- R5: When `frac_num` is 0, or `frac_num` >= `frac_den` (this includes `frac_den` of 0 or 1), every master period is exactly Nc cycles.
- R6: `bclk_en` is high only together with `mclk_en`. It is high exactly on the k-th master pulse after enable when k is a multiple of Mc, where Mc = max(`bclk_div`, 2).
- R7: In the cycle after the k-th master pulse, `bclk_lvl` is 1 exactly when (k mod Mc) >= floor(Mc/2). `bclk_lvl` changes value only in the cycle after a master pulse.
- R8: Dropping and then raising `en` clears the accumulator. The period sequence that follows is identical to the one seen after a fresh enable.
- R9: `mclk_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears all state |
| int_div | input | DIV_W | Integer master divisor N (values below 2 act as 2) |
| frac_num | input | FRAC_W | Fraction numerator b |
| frac_den | input | FRAC_W | Fraction denominator a |
| bclk_div | input | BDIV_W | Bit-clock divisor M (values below 2 act as 2) |
| mclk_en | output | 1 | One-cycle pulse at the end of each master period |
| bclk_en | output | 1 | One-cycle pulse at the end of each bit period |
| bclk_lvl | output | 1 | Bit-clock level, about half low and half high |

## Verification
The bench uses the default widths: an 8-bit integer divisor, a 6-bit fraction and a 6-bit bit divisor. With these widths the largest denominator is 63, and the bench drives a = 63 with b = 62 to stress the accumulator at its widest value. It also reaches the corner cases of the integer and bit divisors:
- an integer divisor of 1, which is clamped to 2;
- a bit divisor of 1, which is clamped to 2;
- an odd bit divisor, where the low half of the bit period is the shorter one;
- an invalid fraction with b = a, which falls back to pure integer division.

One directed run drops `en` when the accumulator is non-zero. It then checks that the stretch pattern restarts from the beginning.

// File: rtl/aclk_div_pkg.sv
package aclk_div_pkg;

    // Master sequencer states
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COUNT = 2'd1,
        S_EXTRA = 2'd2
    } mstate_e;

endpackage

// File: rtl/aclk_frac_acc.sv
// Remainder accumulator: decides whether the current master period is stretched.
module aclk_frac_acc #(
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              advance,
    input  logic [FRAC_W-1:0] num,
    input  logic [FRAC_W-1:0] den,
    output logic              stretch
);
    localparam int ACC_W = FRAC_W + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] den_x;
    logic             frac_ok;

    always_comb begin
        den_x   = {1'b0, den};
        frac_ok = (num != '0) && (num < den);
        sum     = acc + {1'b0, num};
        stretch = frac_ok && (sum >= den_x);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (!en) begin
            acc <= '0;
        end else if (advance && frac_ok) begin
            acc <= stretch ? (sum - den_x) : sum;
        end
    end
endmodule

// File: rtl/aclk_mclk_fsm.sv
// Master-period sequencer: counts Nc cycles, optionally one extra.
module aclk_mclk_fsm
    import aclk_div_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             stretch,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);
    localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

    mstate_e          state, state_n;
    logic [DIV_W-1:0] cnt, cnt_n;
    logic [DIV_W-1:0] div_c;
    logic             at_end;

    assign div_c  = (div < MIN_DIV) ? MIN_DIV : div;
    assign at_end = (cnt == div_c);

    // Next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            S_IDLE: begin
                state_n = S_COUNT;
                cnt_n   = ONE;
            end
            S_COUNT: begin
                if (at_end) begin
                    if (stretch) begin
                        state_n = S_EXTRA;
                    end else begin
                        cnt_n = ONE;
                    end
                end else begin
                    cnt_n = cnt + ONE;
                end
            end
            S_EXTRA: begin
                state_n = S_COUNT;
                cnt_n   = ONE;
            end
            default: begin
                state_n = S_IDLE;
                cnt_n   = '0;
            end
        endcase
        if (!en) begin
            state_n = S_IDLE;
            cnt_n   = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Outputs
    always_comb begin
        tick = 1'b0;
        unique case (state)
            S_COUNT: tick = at_end && !stretch;
            S_EXTRA: tick = 1'b1;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/aclk_bclk_gen.sv
// Bit-clock divider driven by master ticks.
module aclk_bclk_gen #(
    parameter int BDIV_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [BDIV_W-1:0] div,
    output logic              bclk_en,
    output logic              bclk_lvl
);
    localparam logic [BDIV_W-1:0] MIN_DIV = BDIV_W'(2);
    localparam logic [BDIV_W-1:0] ONE     = BDIV_W'(1);

    logic [BDIV_W-1:0] bcnt;
    logic [BDIV_W-1:0] div_c;
    logic [BDIV_W-1:0] half;
    logic              wrap;

    assign div_c   = (div < MIN_DIV) ? MIN_DIV : div;
    assign half    = div_c >> 1;
    assign wrap    = (bcnt == div_c - ONE);
    assign bclk_en = tick && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt     <= '0;
            bclk_lvl <= 1'b0;
        end else if (!en) begin
            bcnt     <= '0;
            bclk_lvl <= 1'b0;
        end else if (tick) begin
            if (wrap) begin
                bcnt     <= '0;
                bclk_lvl <= 1'b0;
            end else begin
                bcnt <= bcnt + ONE;
                if (bcnt == half - ONE) begin
                    bclk_lvl <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/frac_aclk_div.sv
module frac_aclk_div #(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 6,
    parameter int BDIV_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] frac_num,
    input  logic [FRAC_W-1:0] frac_den,
    input  logic [BDIV_W-1:0] bclk_div,
    output logic              mclk_en,
    output logic              bclk_en,
    output logic              bclk_lvl
);
    logic stretch;
    logic tick;

    aclk_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .advance (tick),
        .num     (frac_num),
        .den     (frac_den),
        .stretch (stretch)
    );

    aclk_mclk_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .div     (int_div),
        .stretch (stretch),
        .tick    (tick)
    );

    aclk_bclk_gen #(.BDIV_W(BDIV_W)) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .div      (bclk_div),
        .bclk_en  (bclk_en),
        .bclk_lvl (bclk_lvl)
    );

    assign mclk_en = tick;
endmodule

// File: rtl/aclk_div_chk.sv
module aclk_div_chk #(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DIV_W-1:0]  int_div,
    input logic [FRAC_W-1:0] frac_num,
    input logic [FRAC_W-1:0] frac_den,
    input logic              mclk_en,
    input logic              bclk_en,
    input logic              bclk_lvl
);
    logic [DIV_W:0] gap;
    logic [DIV_W:0] nc;
    logic           int_only;

    assign nc       = (int_div < DIV_W'(2)) ? (DIV_W+1)'(2) : {1'b0, int_div};
    assign int_only = (frac_num == '0) || (frac_num >= frac_den);

    // Cycles elapsed since the previous master pulse (or since enable)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gap <= '0;
        else if (!en)     gap <= '0;
        else if (mclk_en) gap <= (DIV_W+1)'(1);
        else              gap <= gap + (DIV_W+1)'(1);
    end

    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!mclk_en && !bclk_en && !bclk_lvl));

    p_period_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |-> (gap == nc || gap == nc + (DIV_W+1)'(1)));

    p_integer_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_en && int_only) |-> (gap == nc));

    p_bclk_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_en |-> mclk_en);

    p_lvl_moves_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (bclk_lvl != $past(bclk_lvl))) |-> $past(mclk_en));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |=> !mclk_en);
endmodule

bind frac_aclk_div aclk_div_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .int_div  (int_div),
    .frac_num (frac_num),
    .frac_den (frac_den),
    .mclk_en  (mclk_en),
    .bclk_en  (bclk_en),
    .bclk_lvl (bclk_lvl)
);

// File: tb/sim_frac_aclk_div.sv
module sim_frac_aclk_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] int_div = 8'd4;
    logic [5:0] frac_num = 6'd0;
    logic [5:0] frac_den = 6'd1;
    logic [5:0] bclk_div = 6'd8;
    logic       mclk_en, bclk_en, bclk_lvl;

    int checks = 0;
    int errors = 0;
    int wd = 0;

    always #4 clk = ~clk;   // 125 MHz

    frac_aclk_div u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .int_div(int_div),
        .frac_num(frac_num), .frac_den(frac_den), .bclk_div(bclk_div),
        .mclk_en(mclk_en), .bclk_en(bclk_en), .bclk_lvl(bclk_lvl)
    );

    // columns: N, b, a, M, periods observed, expected total cycles
    localparam int NV = 8;
    localparam int VT [NV][6] = '{
        '{4, 0,  1, 8,  8,  32},
        '{4, 1,  3, 3,  6,  26},
        '{5, 2,  5, 4, 10,  54},
        '{1, 0,  1, 2,  4,   8},
        '{3, 3,  3, 1,  6,  18},
        '{6, 7,  8, 8,  8,  55},
        '{2, 1,  2, 5,  4,  10},
        '{2, 62, 63, 2, 63, 188}
    };

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", wd, 100000);
            summary();
            $finish;
        end
    end

    task automatic run_vec(input int n, input int b, input int a, input int m,
                           input int p, input int exp_tot);
        int nc, mc, cyc, last, k, tot, len;
        bit frac, prev;
        nc = (n < 2) ? 2 : n;
        mc = (m < 2) ? 2 : m;
        frac = (b != 0) && (b < a);
        en = 1'b0;
        repeat (2) @(negedge clk);
        int_div = 8'(n); frac_num = 6'(b); frac_den = 6'(a); bclk_div = 6'(m);
        en = 1'b1;
        cyc = 0; last = 0; k = 0; tot = 0; prev = 1'b0;
        while (k < p && cyc < 2000) begin
            @(posedge clk); @(negedge clk);
            cyc++;
            if (prev) begin
                chk(bclk_lvl == ((k % mc) >= (mc / 2)), "R7 bclk level", int'(bclk_lvl),
                    int'((k % mc) >= (mc / 2)));
                prev = 1'b0;
            end
            if (mclk_en) begin
                k++;
                len = cyc - last;
                last = cyc;
                tot += len;
                if (k == 1)      chk(len == nc, "R2 first period", len, nc);
                else if (!frac)  chk(len == nc, "R5 integer period", len, nc);
                else             chk(len == nc || len == nc + 1, "R3 period length", len, nc);
                chk(bclk_en == (k % mc == 0), "R6 bclk pulse", int'(bclk_en), int'(k % mc == 0));
                prev = 1'b1;
            end
        end
        if (frac) chk(tot == exp_tot, "R4 total cycles", tot, exp_tot);
        else      chk(tot == exp_tot, "R5 total cycles", tot, exp_tot);
    endtask

    initial begin
        int cyc, last, k, len;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!mclk_en && !bclk_en && !bclk_lvl, "R1 reset outputs",
            int'({mclk_en, bclk_en, bclk_lvl}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++)
            run_vec(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], VT[i][5]);

        // R1/R8: drop enable with a non-zero accumulator, then restart
        en = 1'b0;
        repeat (2) @(negedge clk);
        int_div = 8'd3; frac_num = 6'd1; frac_den = 6'd2; bclk_div = 6'd2;
        en = 1'b1;
        k = 0; cyc = 0;
        while (k < 3 && cyc < 100) begin
            @(posedge clk); @(negedge clk);
            cyc++;
            if (mclk_en) k++;
        end
        en = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(posedge clk); @(negedge clk);
            chk(!mclk_en && !bclk_en && !bclk_lvl, "R1 disabled outputs",
                int'({mclk_en, bclk_en, bclk_lvl}), 0);
        end
        en = 1'b1;
        k = 0; cyc = 0; last = 0;
        while (k < 2 && cyc < 100) begin
            @(posedge clk); @(negedge clk);
            cyc++;
            if (mclk_en) begin
                k++;
                len = cyc - last;
                last = cyc;
                chk(len == ((k == 1) ? 3 : 4), "R8 restart sequence", len, (k == 1) ? 3 : 4);
            end
        end
        // R9: a pulse is never followed by another in the next cycle
        k = 0;
        for (int j = 0; j < 40; j++) begin
            @(posedge clk); @(negedge clk);
            if (mclk_en && k == 1) chk(1'b0, "R9 back-to-back pulse", 1, 0);
            k = mclk_en ? 1 : 0;
        end
        chk(1'b1, "R9 pulse spacing scan", 1, 1);

        summary();
        $finish;
    end
endmodule